// File: doc/BRIEF.md
# Card power sequencer

This block brings a contact smart card up and down in a fixed, safe order. It owns five enables: the supply step-up pump, the card supply regulator, the card clock, the I/O transceivers and the card reset release. It watches a card-presence indication, an active-low host command line, a supply short-circuit flag and a shutdown request from the supply supervisor. It reports faults to the host on an active-low status line.

Activation starts when a card is present and the host pulls its command low. The enables then come on one at a time, with a programmable number of slow oscillator ticks between stages. Reset is released last, so card software runs only once supply, clock and I/O are up. Teardown removes the enables in the opposite order. A release of the host command, a card removal or a supervisor request starts teardown at once. A supply short is handled according to when it arrives. During power-up it is remembered, and teardown starts once power-up has completed. When the card is already up, teardown starts on the next clock.

Top module: `card_power_seq`

## Requirements
- R1: Card presence is `present_hi_i`=1 or `present_lo_ni`=0. From idle, a high-to-low change of `cmd_ni` sampled while the card is present turns `pump_en_o` on at the next clock edge. With no card present, or with no such edge, nothing is enabled.
- R2: During power-up the enables come on one per stage in the order pump, supply, clock, I/O, reset release (`rst_rel_o`=1). Each stage after the first follows the previous one by exactly STEP_TICKS pulses of `tick_i`.
- R3: When `cmd_ni` is sampled high during power-up or while the card is up, the most recently enabled output turns off at the next clock edge.
- R4: Teardown removes the enables one per stage in the order reset, I/O, clock, supply, pump. Each stage is STEP_TICKS ticks after the previous one, and the block returns to idle with everything off.
- R5: A `short_i` pulse during power-up leaves power-up running to completion with all five enables on. Teardown then starts on the following clock, and `off_no` goes low one clock after the pulse.
- R6: A `short_i` pulse while all five enables are on drops `rst_rel_o` and drives `off_no` low at the next clock edge.
- R7: Losing card presence during power-up or while up starts teardown at the next clock edge and drives `off_no` low.
- R8: A `supv_fault_i` pulse during power-up or while up starts teardown at the next clock edge and drives `off_no` low.
- R9: Once low, `off_no` stays low while `cmd_ni` is low. It returns high one clock after a low-to-high change of `cmd_ni` is sampled.
- R10: A falling `cmd_ni` during teardown is ignored. A new power-up needs teardown to have finished and `cmd_ni` to be seen high and then low again.
- R11: In reset all enables are off and `off_no` is high.
- R12: In idle, `short_i`, `supv_fault_i` and card absence leave `off_no` high and all enables off.
- R13: Stage timing advances only on `tick_i`. With no ticks, the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the slow internal oscillator |
| present_hi_i | input | 1 | Card presence, active high |
| present_lo_ni | input | 1 | Card presence, active low |
| cmd_ni | input | 1 | Host power command, active low |
| short_i | input | 1 | Card supply short-circuit flag |
| supv_fault_i | input | 1 | Supervisor shutdown request |
| pump_en_o | output | 1 | Step-up pump enable |
| vcc_en_o | output | 1 | Card supply regulator enable |
| clk_en_o | output | 1 | Card clock enable |
| io_en_o | output | 1 | I/O transceiver enable (0 = high impedance) |
| rst_rel_o | output | 1 | Card reset release (0 = reset held) |
| off_no | output | 1 | Fault status to host, active low |

## Verification
The bench builds the block with STEP_TICKS=3 and drives `tick_i` by hand. This keeps a full five-stage power-up and teardown within a few dozen cycles. It also lets the bench show that nothing moves after STEP_TICKS-1 ticks and that the next stage appears on the STEP_TICKS-th tick. With stages this short, every fault can be placed in a chosen power-up stage: the short is injected at stage two and removal at stage three. Then both the remembered-short path through full power-up and the early return to idle can be observed.

// File: rtl/card_seq_pkg.sv
`timescale 1ns/1ps
package card_seq_pkg;
  localparam int unsigned NUM_EN = 5;
  localparam int unsigned LVL_W  = $clog2(NUM_EN + 1);

  // enable index = power-up order
  localparam int unsigned EN_PUMP = 0;
  localparam int unsigned EN_VCC  = 1;
  localparam int unsigned EN_CLK  = 2;
  localparam int unsigned EN_IO   = 3;
  localparam int unsigned EN_RST  = 4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_UP   = 2'd1,
    MODE_ON   = 2'd2,
    MODE_DOWN = 2'd3
  } mode_e;
endpackage

// File: rtl/seq_cmd_edge.sv
`timescale 1ns/1ps
module seq_cmd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_ni,
  output logic fall_o,
  output logic rise_o
);
  logic cmd_q;

  // reset low: a command held low through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 1'b0;
    else         cmd_q <= cmd_ni;
  end

  assign fall_o = cmd_q & ~cmd_ni;
  assign rise_o = ~cmd_q & cmd_ni;
endmodule

// File: rtl/seq_step_timer.sv
`timescale 1ns/1ps
module seq_step_timer #(
  parameter int unsigned STEP_TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int unsigned CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign step_o  = run_i & ~clr_i & tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (tick_i)            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/seq_off_latch.sv
`timescale 1ns/1ps
module seq_off_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic off_no
);
  logic off_q;

  // set wins over a same-cycle release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    off_q <= 1'b0;
    else if (set_i) off_q <= 1'b1;
    else if (clr_i) off_q <= 1'b0;
  end

  assign off_no = ~off_q;
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import card_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             cmd_fall_i,
  input  logic             cmd_ni,
  input  logic             present_i,
  input  logic             short_i,
  input  logic             supv_i,
  output logic [LVL_W-1:0] level_o,
  output mode_e            mode_o,
  output logic             clr_o,
  output logic             fault_o
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(NUM_EN);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

  mode_e            mode_q, mode_d;
  logic [LVL_W-1:0] lvl_q, lvl_d, lvl_dn, lvl_up;
  logic             pend_q, pend_d;
  logic             live, start, go_down;

  assign live   = (mode_q == MODE_UP) || (mode_q == MODE_ON);
  assign start  = (mode_q == MODE_IDLE) && cmd_fall_i && present_i;
  assign lvl_dn = lvl_q - LVL_ONE;
  assign lvl_up = lvl_q + LVL_ONE;

  // short during power-up only arms pend_q; it bites once fully up
  always_comb begin
    go_down = 1'b0;
    if (live)              go_down = cmd_ni | ~present_i | supv_i;
    if (mode_q == MODE_ON) go_down = go_down | short_i | pend_q;
  end

  assign fault_o = live & (short_i | ~present_i | supv_i);
  assign clr_o   = start | go_down;

  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    case (mode_q)
      MODE_IDLE: begin
        if (start) begin
          mode_d = MODE_UP;
          lvl_d  = LVL_ONE;
        end
      end
      MODE_UP: begin
        if (go_down) begin
          lvl_d  = lvl_dn;
          mode_d = (lvl_dn == '0) ? MODE_IDLE : MODE_DOWN;
        end else if (step_i) begin
          lvl_d  = lvl_up;
          mode_d = (lvl_up == LVL_FULL) ? MODE_ON : MODE_UP;
        end
      end
      MODE_ON: begin
        if (go_down) begin
          lvl_d  = lvl_dn;
          mode_d = MODE_DOWN;
        end
      end
      MODE_DOWN: begin
        if (step_i) begin
          lvl_d  = lvl_dn;
          mode_d = (lvl_dn == '0) ? MODE_IDLE : MODE_DOWN;
        end
      end
      default: begin
        mode_d = MODE_IDLE;
        lvl_d  = '0;
      end
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (!live || go_down)                 pend_d = 1'b0;
    else if (mode_q == MODE_UP && short_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      lvl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  assign level_o = lvl_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/card_power_seq.sv
`timescale 1ns/1ps
module card_power_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic present_hi_i,
  input  logic present_lo_ni,
  input  logic cmd_ni,
  input  logic short_i,
  input  logic supv_fault_i,
  output logic pump_en_o,
  output logic vcc_en_o,
  output logic clk_en_o,
  output logic io_en_o,
  output logic rst_rel_o,
  output logic off_no
);
  logic             present;
  logic             cmd_fall, cmd_rise;
  logic             step, clr, run, fault;
  logic [LVL_W-1:0] level;
  mode_e            mode;
  logic [NUM_EN-1:0] en;

  assign present = present_hi_i | ~present_lo_ni;
  assign run     = (mode == MODE_UP) || (mode == MODE_DOWN);

  seq_cmd_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_ni (cmd_ni),
    .fall_o (cmd_fall),
    .rise_o (cmd_rise)
  );

  seq_step_timer #(.STEP_TICKS(STEP_TICKS)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .clr_i  (clr),
    .step_o (step)
  );

  seq_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .cmd_fall_i (cmd_fall),
    .cmd_ni     (cmd_ni),
    .present_i  (present),
    .short_i    (short_i),
    .supv_i     (supv_fault_i),
    .level_o    (level),
    .mode_o     (mode),
    .clr_o      (clr),
    .fault_o    (fault)
  );

  seq_off_latch i_off (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fault),
    .clr_i  (cmd_rise),
    .off_no (off_no)
  );

  // enable k is on while level exceeds k: one bit moves per stage
  for (genvar k = 0; k < NUM_EN; k++) begin : g_en
    assign en[k] = (level > LVL_W'(k));
  end

  assign pump_en_o = en[EN_PUMP];
  assign vcc_en_o  = en[EN_VCC];
  assign clk_en_o  = en[EN_CLK];
  assign io_en_o   = en[EN_IO];
  assign rst_rel_o = en[EN_RST];
endmodule

// File: rtl/card_power_seq_chk.sv
`timescale 1ns/1ps
module card_power_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic present_hi_i,
  input logic present_lo_ni,
  input logic cmd_ni,
  input logic short_i,
  input logic supv_fault_i,
  input logic pump_en_o,
  input logic vcc_en_o,
  input logic clk_en_o,
  input logic io_en_o,
  input logic rst_rel_o,
  input logic off_no
);
  logic [4:0] en_w;
  logic       card_in;
  assign en_w    = {rst_rel_o, io_en_o, clk_en_o, vcc_en_o, pump_en_o};
  assign card_in = present_hi_i | ~present_lo_ni;

  a_r1_start_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> ($past(!cmd_ni) && $past(card_in)));

  a_r2_reset_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_rel_o) |-> (pump_en_o && vcc_en_o && clk_en_o && io_en_o));

  a_r2_single_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_w ^ $past(en_w)) <= 1);

  a_r4_supply_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> (!clk_en_o && !io_en_o && !rst_rel_o));

  a_r3_release_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_o && cmd_ni) |=> !rst_rel_o);

  a_r6_short_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_o && short_i) |=> !rst_rel_o);

  a_r8_supv_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_o && supv_fault_i) |=> !rst_rel_o);

  a_r9_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_no && !cmd_ni) |=> !off_no);
endmodule

bind card_power_seq card_power_seq_chk i_chk (.*);

// File: tb/test_card_power_seq.sv
`timescale 1ns/1ps
module test_card_power_seq;
  localparam int unsigned STEP = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pres_hi = 1'b0, pres_lo_n = 1'b1, cmd_n = 1'b1, short_f = 1'b0, supv = 1'b0;
  logic pump_en, vcc_en, clk_en, io_en, rst_rel, off_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  card_power_seq #(.STEP_TICKS(STEP)) i_card_power_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .present_hi_i(pres_hi), .present_lo_ni(pres_lo_n), .cmd_ni(cmd_n),
    .short_i(short_f), .supv_fault_i(supv),
    .pump_en_o(pump_en), .vcc_en_o(vcc_en), .clk_en_o(clk_en),
    .io_en_o(io_en), .rst_rel_o(rst_rel), .off_no(off_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_lvl(input string req, input int lvl);
    logic [4:0] act, exp;
    act = {rst_rel, io_en, clk_en, vcc_en, pump_en};
    exp = 5'((32'd1 << lvl) - 32'd1);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s enables act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_off(input string req, input logic exp);
    n_chk++;
    if (off_n !== exp) begin
      n_bad++;
      $display("FAIL %s off_no act=%b exp=%b at %0t", req, off_n, exp, $time);
    end
  endtask

  // starts from idle with cmd high; ends with all five enables on
  task automatic activate();
    cmd_n = 1'b1; cyc(1);
    cmd_n = 1'b0; cyc(1);
    chk_lvl("R1", 1);
    cyc(10);
    chk_lvl("R13", 1);
    for (int k = 2; k <= 5; k++) begin
      tk(STEP - 1); chk_lvl("R2", k - 1);
      tk(1);        chk_lvl("R2", k);
    end
  endtask

  task automatic run_down(input int from);
    for (int k = from; k >= 1; k--) begin
      tk(STEP - 1); chk_lvl("R4", k);
      tk(1);        chk_lvl("R4", k - 1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(2);
    chk_lvl("R11", 0); chk_off("R11", 1'b1);
    rst_n = 1'b1; cyc(2);
    chk_lvl("R11", 0); chk_off("R11", 1'b1);
  endtask

  task automatic t_absent();
    pres_hi = 1'b0; pres_lo_n = 1'b1;
    cmd_n = 1'b1; cyc(1);
    cmd_n = 1'b0; cyc(2); tk(2 * STEP);
    chk_lvl("R1", 0);
    cmd_n = 1'b1; cyc(1);
  endtask

  task automatic t_normal();
    pres_hi = 1'b1;
    activate();
    cmd_n = 1'b1; cyc(1);
    chk_lvl("R3", 4); chk_off("R3", 1'b1);
    cmd_n = 1'b0; cyc(1);                  // fall during teardown
    run_down(4);
    tk(3 * STEP);
    chk_lvl("R10", 0);
    cmd_n = 1'b1; cyc(1);
    pres_hi = 1'b0;
  endtask

  task automatic t_short_up();
    pres_lo_n = 1'b0;
    activate();
    short_f = 1'b1; cyc(1); short_f = 1'b0;
    chk_lvl("R6", 4); chk_off("R6", 1'b0);
    run_down(4);
    chk_off("R9", 1'b0);
    cmd_n = 1'b1; cyc(1);
    chk_off("R9", 1'b1);
    pres_lo_n = 1'b1;
  endtask

  task automatic t_short_act();
    pres_hi = 1'b1;
    cmd_n = 1'b1; cyc(1);
    cmd_n = 1'b0; cyc(1);
    chk_lvl("R1", 1);
    tk(STEP); chk_lvl("R2", 2);
    short_f = 1'b1; cyc(1); short_f = 1'b0;
    chk_off("R5", 1'b0); chk_lvl("R5", 2);
    tk(STEP); chk_lvl("R5", 3);
    tk(STEP); chk_lvl("R5", 4);
    tk(STEP); chk_lvl("R5", 5);
    cyc(1);   chk_lvl("R5", 4);
    run_down(4);
    cmd_n = 1'b1; cyc(1);
    chk_off("R9", 1'b1);
    pres_hi = 1'b0;
  endtask

  task automatic t_removal();
    pres_hi = 1'b1;
    cmd_n = 1'b1; cyc(1);
    cmd_n = 1'b0; cyc(1);
    tk(STEP); tk(STEP);
    chk_lvl("R2", 3);
    pres_hi = 1'b0; cyc(1);
    chk_lvl("R7", 2); chk_off("R7", 1'b0);
    run_down(2);
    cmd_n = 1'b1; cyc(1);
    chk_off("R9", 1'b1);
    short_f = 1'b1; cyc(1); short_f = 1'b0;
    supv = 1'b1; cyc(1); supv = 1'b0;
    cmd_n = 1'b0; cyc(2);
    chk_off("R12", 1'b1); chk_lvl("R12", 0);
    cmd_n = 1'b1; cyc(1);
  endtask

  task automatic t_supv();
    pres_hi = 1'b1;
    activate();
    supv = 1'b1; cyc(1); supv = 1'b0;
    chk_lvl("R8", 4); chk_off("R8", 1'b0);
    run_down(4);
    tk(2 * STEP);
    chk_lvl("R10", 0);
    cmd_n = 1'b1; cyc(1);
    chk_off("R9", 1'b1);
    cmd_n = 1'b0; cyc(1);
    chk_lvl("R10", 1);
    cmd_n = 1'b1; cyc(1);
    chk_lvl("R3", 0);
    pres_hi = 1'b0;
  endtask

  initial begin
    t_reset();
    t_absent();
    t_normal();
    t_short_up();
    t_short_act();
    t_removal();
    t_supv();
    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule